// File: doc/BRIEF.md
# Stack Window Guard

This block watches the load/store address path of a 32-bit processor and flags accesses that go through the stack pointer register (register 1) but land outside a programmable address window. Software sets the window through two bound registers. The lower bound sits at special-register select 0x800 and the upper bound at 0x802. Software writes and reads each bound in full through the processor's special-register move path.

For every load or store, the pipeline presents the following:
- a valid strobe;
- the base and index register numbers;
- a flag telling the register+immediate form from the register+register form;
- the final summed effective address.

The guard compares that address against the window. An eligible access that falls outside the window raises a one-cycle hardware exception request. At the same time the guard latches the faulting address and the cause code for the exception logic.

After reset the window spans the whole address space, so the guard never fires until software narrows the window.

Top module: `stk_window_guard`

## Requirements
- R1: After reset the lower bound reads 0 and the upper bound reads 0xFFFFFFFF. `exc_req`, `exc_addr` and `exc_cause` are all 0, and no address of an eligible access causes a fault.
- R2: A special-register write with select 0x800 loads the lower bound, and one with select 0x802 loads the upper bound, all 32 bits. A read with either select returns that bound. Any other select reads as 0, and a write with any other select leaves both bounds unchanged.
- R3: A bound write takes effect for accesses presented from the next cycle onward. An access in the same cycle as the write is checked against the old bounds.
- R4: The window is inclusive: an effective address equal to the lower or the upper bound never faults.
- R5: A valid, eligible access whose effective address is below the lower bound or above the upper bound (unsigned) raises `exc_req` in the cycle after the access.
- R6: An access is eligible when its base register number is 1. In the register+register form (`ls_imm_form`=0) it is also eligible when its index register number is 1. In the register+immediate form the index number is ignored.
- R7: On a fault, `exc_addr` takes the faulting effective address and `exc_cause` takes the value 7, both visible in the same cycle as `exc_req`.
- R8: When no fault occurs (access invalid, not eligible, or inside the window), `exc_req` is 0 in the next cycle and `exc_addr` and `exc_cause` keep their values.
- R9: `exc_req` is a single-cycle pulse per faulting access. It drops in the cycle after the pulse unless another faulting access was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spr_wr_en | input | 1 | Special-register write strobe |
| spr_wr_sel | input | 14 | Special-register write select |
| spr_wr_data | input | 32 | Special-register write data |
| spr_rd_sel | input | 14 | Special-register read select |
| spr_rd_data | output | 32 | Special-register read data (combinational) |
| ls_valid | input | 1 | Load/store access valid |
| ls_ra | input | 5 | Base register number |
| ls_rb | input | 5 | Index register number |
| ls_imm_form | input | 1 | 1 = register+immediate form, 0 = register+register form |
| ls_ea | input | 32 | Final effective address |
| exc_req | output | 1 | Hardware exception request pulse |
| exc_cause | output | 5 | Latched cause code |
| exc_addr | output | 32 | Latched faulting address |

## Verification
The bench builds the guard with its default parameters:
- a 32-bit address,
- 14-bit special-register selects at 0x800 and 0x802,
- stack register 1,
- cause code 7.

With the full 32-bit address width, the reset window's extremes (0 and 0xFFFFFFFF) become reachable as probe addresses. It also lets the bench place a narrow window of 0x1000 to 0x1FFF and probe one address either side of each bound. Keeping register 1 as the stack register lets the table cover base-only, index-only and both-operand eligibility in both addressing forms.

// File: rtl/stkg_pkg.sv
package stkg_pkg;

  // Which bound register a special-register select addresses.
  typedef enum logic [1:0] {
    BSEL_NONE = 2'd0,
    BSEL_LO   = 2'd1,
    BSEL_HI   = 2'd2
  } bsel_e;

  // Result of the window comparison.
  typedef struct packed {
    logic below;
    logic above;
  } win_cmp_t;

endpackage

// File: rtl/stkg_bound_regs.sv
module stkg_bound_regs
  import stkg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SPR_W  = 14,
  parameter logic [SPR_W-1:0] LO_SEL = 14'h800,
  parameter logic [SPR_W-1:0] HI_SEL = 14'h802
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SPR_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SPR_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q
);

  bsel_e             wr_bsel;
  bsel_e             rd_bsel;
  logic              lo_en;
  logic              hi_en;
  logic [ADDR_W-1:0] lo_d;
  logic [ADDR_W-1:0] hi_d;

  // Select decode for the write and read paths.
  always_comb begin
    wr_bsel = BSEL_NONE;
    if (wr_sel == LO_SEL) wr_bsel = BSEL_LO;
    else if (wr_sel == HI_SEL) wr_bsel = BSEL_HI;
    rd_bsel = BSEL_NONE;
    if (rd_sel == LO_SEL) rd_bsel = BSEL_LO;
    else if (rd_sel == HI_SEL) rd_bsel = BSEL_HI;
  end

  // Next-state and clock enables.
  always_comb begin
    lo_en = wr_en && (wr_bsel == BSEL_LO);
    hi_en = wr_en && (wr_bsel == BSEL_HI);
    lo_d  = wr_data;
    hi_d  = wr_data;
  end

  // Bound registers; reset leaves the window wide open.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '1;
    end else begin
      if (lo_en) lo_q <= lo_d;
      if (hi_en) hi_q <= hi_d;
    end
  end

  // Read mux.
  always_comb begin
    unique case (rd_bsel)
      BSEL_LO: rd_data = lo_q;
      BSEL_HI: rd_data = hi_q;
      default: rd_data = '0;
    endcase
  end

  // R2
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == LO_SEL) |=> (lo_q == $past(wr_data)));

  // R2
  hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == HI_SEL) |=> (hi_q == $past(wr_data)));

  // R2
  other_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (wr_sel != LO_SEL && wr_sel != HI_SEL)) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/stkg_use_decode.sv
module stkg_use_decode #(
  parameter int REG_W = 5,
  parameter logic [REG_W-1:0] SP_REG = 5'd1
) (
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  input  logic             imm_form,
  output logic             use_sp
);

  logic base_hit;
  logic index_hit;

  always_comb begin
    base_hit  = (ra == SP_REG);
    // The index operand only exists in the register+register form.
    index_hit = !imm_form && (rb == SP_REG);
    use_sp    = base_hit || index_hit;
  end

endmodule

// File: rtl/stkg_window_cmp.sv
module stkg_window_cmp
  import stkg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output win_cmp_t          res,
  output logic              outside
);

  // Unsigned compare; equality with either bound is inside.
  always_comb begin
    res.below = (ea < lo);
    res.above = (ea > hi);
    outside   = res.below || res.above;
  end

endmodule

// File: rtl/stkg_fault_capture.sv
module stkg_fault_capture #(
  parameter int ADDR_W  = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_CODE = 5'd7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault,
  input  logic [ADDR_W-1:0]  ea,
  output logic               exc_req,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [ADDR_W-1:0]  exc_addr
);

  logic               req_d;
  logic               cap_en;
  logic [CAUSE_W-1:0] cause_d;
  logic [ADDR_W-1:0]  addr_d;

  always_comb begin
    req_d   = fault;
    cap_en  = fault;
    cause_d = CAUSE_CODE;
    addr_d  = ea;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req   <= 1'b0;
      exc_cause <= '0;
      exc_addr  <= '0;
    end else begin
      exc_req <= req_d;
      if (cap_en) begin
        exc_cause <= cause_d;
        exc_addr  <= addr_d;
      end
    end
  end

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (exc_req && exc_addr == $past(ea) && exc_cause == CAUSE_CODE));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> (!exc_req && $stable(exc_addr) && $stable(exc_cause)));

endmodule

// File: rtl/stk_window_guard.sv
module stk_window_guard
  import stkg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SPR_W   = 14,
  parameter int REG_W   = 5,
  parameter int CAUSE_W = 5,
  parameter logic [SPR_W-1:0]   LO_SEL     = 14'h800,
  parameter logic [SPR_W-1:0]   HI_SEL     = 14'h802,
  parameter logic [REG_W-1:0]   SP_REG     = 5'd1,
  parameter logic [CAUSE_W-1:0] CAUSE_CODE = 5'd7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spr_wr_en,
  input  logic [SPR_W-1:0]   spr_wr_sel,
  input  logic [ADDR_W-1:0]  spr_wr_data,
  input  logic [SPR_W-1:0]   spr_rd_sel,
  output logic [ADDR_W-1:0]  spr_rd_data,
  input  logic               ls_valid,
  input  logic [REG_W-1:0]   ls_ra,
  input  logic [REG_W-1:0]   ls_rb,
  input  logic               ls_imm_form,
  input  logic [ADDR_W-1:0]  ls_ea,
  output logic               exc_req,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [ADDR_W-1:0]  exc_addr
);

  logic [ADDR_W-1:0] lo_q;
  logic [ADDR_W-1:0] hi_q;
  logic              use_sp;
  logic              outside;
  win_cmp_t          cmp_res;
  logic              fault;

  stkg_bound_regs #(
    .ADDR_W (ADDR_W),
    .SPR_W  (SPR_W),
    .LO_SEL (LO_SEL),
    .HI_SEL (HI_SEL)
  ) u_bounds (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (spr_wr_en),
    .wr_sel  (spr_wr_sel),
    .wr_data (spr_wr_data),
    .rd_sel  (spr_rd_sel),
    .rd_data (spr_rd_data),
    .lo_q    (lo_q),
    .hi_q    (hi_q)
  );

  stkg_use_decode #(
    .REG_W  (REG_W),
    .SP_REG (SP_REG)
  ) u_decode (
    .ra       (ls_ra),
    .rb       (ls_rb),
    .imm_form (ls_imm_form),
    .use_sp   (use_sp)
  );

  stkg_window_cmp #(
    .ADDR_W (ADDR_W)
  ) u_cmp (
    .ea      (ls_ea),
    .lo      (lo_q),
    .hi      (hi_q),
    .res     (cmp_res),
    .outside (outside)
  );

  always_comb begin
    fault = ls_valid && use_sp && outside;
  end

  stkg_fault_capture #(
    .ADDR_W     (ADDR_W),
    .CAUSE_W    (CAUSE_W),
    .CAUSE_CODE (CAUSE_CODE)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault     (fault),
    .ea        (ls_ea),
    .exc_req   (exc_req),
    .exc_cause (exc_cause),
    .exc_addr  (exc_addr)
  );

  // R4
  bound_incl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_q <= hi_q) && (ls_ea == lo_q || ls_ea == hi_q)) |-> !outside);

  // R6
  elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_ra != SP_REG && (ls_imm_form || ls_rb != SP_REG)) |-> !use_sp);

  // R5
  req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ($past(ls_valid) && $past(use_sp)));

  // R1
  open_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q == '0 && hi_q == '1) |-> !cmp_res.below && !cmp_res.above);

endmodule

// File: tb/stk_window_guard_tb.sv
`timescale 1ns/1ps
module stk_window_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spr_wr_en;
  logic [13:0] spr_wr_sel;
  logic [31:0] spr_wr_data;
  logic [13:0] spr_rd_sel;
  logic [31:0] spr_rd_data;
  logic        ls_valid;
  logic [4:0]  ls_ra;
  logic [4:0]  ls_rb;
  logic        ls_imm_form;
  logic [31:0] ls_ea;
  logic        exc_req;
  logic [4:0]  exc_cause;
  logic [31:0] exc_addr;

  always #2.5 clk = ~clk;

  stk_window_guard u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .spr_wr_en   (spr_wr_en),
    .spr_wr_sel  (spr_wr_sel),
    .spr_wr_data (spr_wr_data),
    .spr_rd_sel  (spr_rd_sel),
    .spr_rd_data (spr_rd_data),
    .ls_valid    (ls_valid),
    .ls_ra       (ls_ra),
    .ls_rb       (ls_rb),
    .ls_imm_form (ls_imm_form),
    .ls_ea       (ls_ea),
    .exc_req     (exc_req),
    .exc_cause   (exc_cause),
    .exc_addr    (exc_addr)
  );

  // Vector: {ra[43:39], rb[38:34], imm_form[33], ea[32:1], expect_fault[0]}
  // Window during the table: 0x1000 .. 0x1FFF
  localparam int NVEC = 10;
  localparam logic [43:0] VEC [NVEC] = '{
    {5'd1, 5'd0, 1'b1, 32'h0000_1000, 1'b0},  // R4 low bound
    {5'd1, 5'd0, 1'b1, 32'h0000_0FFF, 1'b1},  // R5 below
    {5'd1, 5'd3, 1'b0, 32'h0000_1FFF, 1'b0},  // R4 high bound
    {5'd1, 5'd3, 1'b0, 32'h0000_2000, 1'b1},  // R5 above
    {5'd2, 5'd1, 1'b0, 32'h0000_2000, 1'b1},  // R6 index r1, reg+reg
    {5'd2, 5'd1, 1'b1, 32'h0000_2000, 1'b0},  // R6 index ignored, reg+imm
    {5'd4, 5'd5, 1'b0, 32'hFFFF_FFFF, 1'b0},  // R6 no r1
    {5'd1, 5'd1, 1'b0, 32'h0000_0000, 1'b1},  // R5 both r1
    {5'd1, 5'd0, 1'b1, 32'h0000_1800, 1'b0},  // R5 inside
    {5'd0, 5'd1, 1'b0, 32'h0000_0010, 1'b1}   // R6 index r1
  };

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] exp_addr = 32'h0;
  logic [4:0]  exp_cause = 5'd0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_spr(input logic [13:0] sel, input logic [31:0] data);
    @(negedge clk);
    spr_wr_en   = 1'b1;
    spr_wr_sel  = sel;
    spr_wr_data = data;
    @(negedge clk);
    spr_wr_en   = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [13:0] sel, input logic [31:0] exp);
    spr_rd_sel = sel;
    #0.5;
    chk(req, spr_rd_data, exp);
  endtask

  // Present one access for one cycle; check outputs in the following cycle.
  task automatic access(input string req, input logic [4:0] ra, input logic [4:0] rb,
                        input logic imm, input logic [31:0] ea, input logic exp_fault);
    @(negedge clk);
    ls_valid = 1'b1; ls_ra = ra; ls_rb = rb; ls_imm_form = imm; ls_ea = ea;
    @(negedge clk);
    ls_valid = 1'b0;
    if (exp_fault) begin
      exp_addr  = ea;
      exp_cause = 5'd7;
    end
    chk(req, {31'b0, exc_req}, {31'b0, exp_fault});
    chk(req, exc_addr, exp_addr);
    chk(req, {27'b0, exc_cause}, {27'b0, exp_cause});
    @(negedge clk);
    chk("R9", {31'b0, exc_req}, 32'h0);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    spr_wr_en = 1'b0; spr_wr_sel = '0; spr_wr_data = '0; spr_rd_sel = '0;
    ls_valid = 1'b0; ls_ra = '0; ls_rb = '0; ls_imm_form = 1'b0; ls_ea = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1", 14'h800, 32'h0000_0000);
    rd_chk("R1", 14'h802, 32'hFFFF_FFFF);
    chk("R1", {31'b0, exc_req}, 32'h0);
    chk("R1", exc_addr, 32'h0);
    chk("R1", {27'b0, exc_cause}, 32'h0);
    access("R1", 5'd1, 5'd0, 1'b1, 32'h0000_0000, 1'b0);
    access("R1", 5'd1, 5'd1, 1'b0, 32'hFFFF_FFFF, 1'b0);

    // R2 bound access, full width, other selects
    wr_spr(14'h800, 32'hA5A5_5A5A);
    rd_chk("R2", 14'h800, 32'hA5A5_5A5A);
    wr_spr(14'h800, 32'h0000_1000);
    wr_spr(14'h802, 32'h0000_1FFF);
    wr_spr(14'h801, 32'hDEAD_BEEF);
    rd_chk("R2", 14'h800, 32'h0000_1000);
    rd_chk("R2", 14'h802, 32'h0000_1FFF);
    rd_chk("R2", 14'h801, 32'h0000_0000);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      access("R5/R6/R7", VEC[i][43:39], VEC[i][38:34], VEC[i][33], VEC[i][32:1], VEC[i][0]);
    end

    // R8: out-of-window r1 address without valid
    @(negedge clk);
    ls_valid = 1'b0; ls_ra = 5'd1; ls_imm_form = 1'b1; ls_ea = 32'h0000_5000;
    @(negedge clk);
    chk("R8", {31'b0, exc_req}, 32'h0);
    chk("R8", exc_addr, exp_addr);
    chk("R8", {27'b0, exc_cause}, {27'b0, exp_cause});

    // R3: same-cycle write uses old bounds, next access uses new
    @(negedge clk);
    spr_wr_en = 1'b1; spr_wr_sel = 14'h802; spr_wr_data = 32'h0000_2FFF;
    ls_valid = 1'b1; ls_ra = 5'd1; ls_rb = 5'd0; ls_imm_form = 1'b1; ls_ea = 32'h0000_2800;
    @(negedge clk);
    spr_wr_en = 1'b0;
    ls_valid = 1'b0;
    exp_addr = 32'h0000_2800;
    chk("R3", {31'b0, exc_req}, 32'h1);
    chk("R3", exc_addr, exp_addr);
    access("R3", 5'd1, 5'd0, 1'b1, 32'h0000_2800, 1'b0);

    // R9: back-to-back faults give back-to-back pulses, then drop
    @(negedge clk);
    ls_valid = 1'b1; ls_ra = 5'd1; ls_imm_form = 1'b1; ls_ea = 32'h0000_0100;
    @(negedge clk);
    chk("R9", {31'b0, exc_req}, 32'h1);
    chk("R9", exc_addr, 32'h0000_0100);
    ls_ea = 32'h0000_3000;
    @(negedge clk);
    ls_valid = 1'b0;
    chk("R9", {31'b0, exc_req}, 32'h1);
    chk("R9", exc_addr, 32'h0000_3000);
    @(negedge clk);
    chk("R9", {31'b0, exc_req}, 32'h0);

    finish_run();
  end

endmodule